// File: doc/BRIEF.md
# Inbound Ethernet Frame Steering Classifier

The block sits on the receive side of an Ethernet port and takes frames one byte per beat on a valid/ready stream, with a marker on the final byte. It captures the first 42 bytes of each frame, which covers the Ethernet, IPv4 and UDP headers. From those bytes it decides whether the frame is for this station and which of two downstream sinks gets it. Frames whose destination address is neither the local station address nor all-ones are consumed and thrown away without any output beat.

Accepted frames that carry a UDP datagram to the local IPv4 address and the configured UDP port are cut down to the datagram payload and sent to the stream sink. That sink also carries a context marker taken from a configuration pin. Every other accepted frame goes to the register sink. There it is preceded by its two type bytes, and the bytes from offset 14 onward follow. A frame that ends before the headers its type implies still goes to the register sink, but with an error marker on every beat.

All three streams follow valid/ready rules. A beat moves on a cycle where valid and ready are both high. A sink that holds ready low stalls the block with its data held stable. While header bytes are being replayed to the register sink, input ready is low. While the rest of a frame is passed through, input ready follows the chosen sink's ready combinationally. The decision is taken one cycle after the last captured header byte and is held until the frame's final byte.

Top module: `eth_ingress_steer`

## Requirements
- R1: A frame of at least 6 bytes whose bytes 0..5, read first byte most significant, equal `local_mac` or 48'hFFFF_FFFF_FFFF is accepted and produces output beats on exactly one sink.
- R2: Any other frame, including one shorter than 6 bytes, is consumed to its last byte with no valid beat on either sink.
- R3: An accepted frame not sent to the stream sink appears on the register sink as byte 12, then byte 13, then bytes 14 onward in order, with `core_last` only on the final beat.
- R4: A frame goes to the stream sink when all of these hold: it is accepted; it has at least 42 bytes; bytes 12..13 are 16'h0800; byte 14 is 8'h45; byte 23 is 8'd17; bytes 30..33 equal `local_ip`; bytes 36..37 equal `UDP_PORT` (default 1000). Only bytes 42 onward are sent there, with `strm_last` on the final beat; a 42-byte frame gives no beat. Type 16'h0806 and all other types go to the register sink.
- R5: A frame that is accepted and has fewer than 14 bytes, or that has type 16'h0800 and fewer than 42 bytes, goes to the register sink with `core_err` high on every beat. Type bytes it lacks are sent as 8'h00.
- R6: `core_err` is low on every beat of a frame that does not meet R5.
- R7: On every stream beat, `strm_ctx` equals the value `ctx_mode` had when the routing decision was taken.
- R8: The two sinks are never valid in the same cycle, and the route chosen for a frame does not change before the frame's last byte.
- R9: A stalled sink sees its beat held with stable data; input ready stays low while the stalled beat is a replayed header byte.
- R10: After reset, `in_ready` is high and neither sink is valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| local_mac | input | 48 | Station address |
| local_ip | input | 32 | Station IPv4 address |
| ctx_mode | input | 1 | Marks stream-sink packets as context packets |
| in_valid | input | 1 | Input byte valid |
| in_data | input | 8 | Input byte |
| in_last | input | 1 | Final byte of frame |
| in_ready | output | 1 | Input byte accepted |
| core_valid | output | 1 | Register sink beat valid |
| core_data | output | 8 | Register sink byte |
| core_last | output | 1 | Register sink final beat |
| core_err | output | 1 | Frame shorter than its headers |
| core_ready | input | 1 | Register sink ready |
| strm_valid | output | 1 | Stream sink beat valid |
| strm_data | output | 8 | Stream sink byte |
| strm_last | output | 1 | Stream sink final beat |
| strm_ctx | output | 1 | Context packet marker |
| strm_ready | input | 1 | Stream sink ready |

## Verification
The bench targets the length boundaries: frames that stop at 5, 12, 13, 14, 30, 42 and 43 bytes. An off-by-one in the length compare would send the wrong stream, drop the error marker, or emit a stray byte. It also sends frames that miss the stream match by a single field: port, protocol, header-length byte or address. A matcher that skipped one of those fields would move such a frame to the stream sink without its type bytes. A directed stall checks that a held register-sink beat keeps its data and that the input stays blocked. A design that advanced the replay pointer without a handshake would lose bytes there.

// File: rtl/ings_pkg.sv
`timescale 1ns/1ps
package ings_pkg;
  localparam int BYTE_W    = 8;
  localparam int MAC_BYTES = 6;
  localparam int ETH_HDR   = 14;
  localparam int IP_HDR    = 20;
  localparam int UDP_HDR   = 8;
  localparam int HDR_LEN   = ETH_HDR + IP_HDR + UDP_HDR;
  localparam int CNT_W     = $clog2(HDR_LEN + 1);

  // byte offsets inside the captured header
  localparam int OFF_ETYPE = 2 * MAC_BYTES;
  localparam int OFF_VIHL  = ETH_HDR;
  localparam int OFF_PROTO = ETH_HDR + 9;
  localparam int OFF_DIP   = ETH_HDR + 16;
  localparam int OFF_DPORT = ETH_HDR + IP_HDR + 2;

  localparam logic [15:0] ETYPE_IPV4 = 16'h0800;
  localparam logic [7:0]  VIHL_PLAIN = 8'h45;
  localparam logic [7:0]  PROTO_UDP  = 8'd17;

  typedef enum logic [1:0] {
    RT_DROP = 2'd0,
    RT_CORE = 2'd1,
    RT_STRM = 2'd2
  } route_e;

  typedef enum logic [2:0] {
    ST_CAP    = 3'd0,
    ST_DEC    = 3'd1,
    ST_REPLAY = 3'd2,
    ST_PASS   = 3'd3,
    ST_DRAIN  = 3'd4
  } state_e;
endpackage

// File: rtl/ings_hdr_store.sv
`timescale 1ns/1ps
module ings_hdr_store
  import ings_pkg::*;
#(
  parameter int LEN = HDR_LEN,
  parameter int CW  = CNT_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [BYTE_W-1:0] wr_byte,
  input  logic              clr,
  output logic [BYTE_W-1:0] hdr [LEN],
  output logic [CW-1:0]     cnt
);
  always_ff @(posedge clk) begin
    if (!rst_n)      cnt <= '0;
    else if (clr)    cnt <= '0;
    else if (wr_en)  cnt <= cnt + 1'b1;
  end

  for (genvar g = 0; g < LEN; g++) begin : g_slot
    localparam logic [CW-1:0] SLOT = CW'(g);
    always_ff @(posedge clk) begin
      if (!rst_n)                      hdr[g] <= '0;
      else if (wr_en && cnt == SLOT)   hdr[g] <= wr_byte;
    end
  end

  // R4
  cap_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == CW'(LEN)) |=> (cnt == '0 || cnt == CW'(LEN)));
endmodule

// File: rtl/ings_match.sv
`timescale 1ns/1ps
module ings_match
  import ings_pkg::*;
#(
  parameter int          LEN  = HDR_LEN,
  parameter int          CW   = CNT_W,
  parameter logic [15:0] PORT = 16'd1000
) (
  input  logic [BYTE_W-1:0] hdr [LEN],
  input  logic [CW-1:0]     len,
  input  logic [47:0]       local_mac,
  input  logic [31:0]       local_ip,
  output route_e            route,
  output logic              short_err
);
  localparam logic [CW-1:0] N_MAC = CW'(MAC_BYTES);
  localparam logic [CW-1:0] N_ETH = CW'(ETH_HDR);
  localparam logic [CW-1:0] N_ALL = CW'(LEN);

  logic [47:0] dst;
  logic [31:0] dip;
  logic [15:0] etype, dport;
  logic        mac_ok, have_eth, full, is_ip, hit;

  always_comb begin
    for (int k = 0; k < MAC_BYTES; k++) dst[47 - 8*k -: 8] = hdr[k];
    for (int k = 0; k < 4; k++)         dip[31 - 8*k -: 8] = hdr[OFF_DIP + k];
    etype    = {hdr[OFF_ETYPE], hdr[OFF_ETYPE + 1]};
    dport    = {hdr[OFF_DPORT], hdr[OFF_DPORT + 1]};
    mac_ok   = (len >= N_MAC) && ((dst == local_mac) || (&dst));
    have_eth = (len >= N_ETH);
    full     = (len == N_ALL);
    is_ip    = have_eth && (etype == ETYPE_IPV4);
    hit      = is_ip && full && (hdr[OFF_VIHL] == VIHL_PLAIN) &&
               (hdr[OFF_PROTO] == PROTO_UDP) && (dip == local_ip) &&
               (dport == PORT);
    short_err = !have_eth || (is_ip && !full);
    if (!mac_ok)   route = RT_DROP;
    else if (hit)  route = RT_STRM;
    else           route = RT_CORE;
  end
endmodule

// File: rtl/ings_steer.sv
`timescale 1ns/1ps
module ings_steer
  import ings_pkg::*;
#(
  parameter int LEN = HDR_LEN,
  parameter int CW  = CNT_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctx_mode,
  input  logic              in_valid,
  input  logic [BYTE_W-1:0] in_data,
  input  logic              in_last,
  output logic              in_ready,
  output logic              cap_wr,
  output logic              cap_clr,
  input  logic [CW-1:0]     cap_cnt,
  input  logic [BYTE_W-1:0] hdr [LEN],
  input  route_e            route,
  input  logic              short_err,
  output logic              core_valid,
  output logic [BYTE_W-1:0] core_data,
  output logic              core_last,
  output logic              core_err,
  input  logic              core_ready,
  output logic              strm_valid,
  output logic [BYTE_W-1:0] strm_data,
  output logic              strm_last,
  output logic              strm_ctx,
  input  logic              strm_ready
);
  localparam logic [CW-1:0] IDX_ET   = CW'(OFF_ETYPE);
  localparam logic [CW-1:0] N_ETH    = CW'(ETH_HDR);
  localparam logic [CW-1:0] LAST_IDX = CW'(LEN - 1);

  state_e          state_q, state_d;
  route_e          route_q;
  logic            err_q, ctx_q, done_q;
  logic [CW-1:0]   len_q, rd_idx;
  logic [CW-1:0]   rep_end;
  logic            at_end;
  logic [BYTE_W-1:0] rep_byte;
  logic            in_fire;

  assign rep_end  = (len_q < N_ETH) ? N_ETH : len_q;
  assign at_end   = (rd_idx == rep_end - 1'b1);
  assign rep_byte = (rd_idx < len_q) ? hdr[rd_idx] : '0;
  assign in_fire  = in_valid && in_ready;

  always_comb begin
    in_ready   = 1'b0;
    cap_wr     = 1'b0;
    cap_clr    = 1'b0;
    core_valid = 1'b0;
    core_data  = '0;
    core_last  = 1'b0;
    strm_valid = 1'b0;
    strm_data  = '0;
    strm_last  = 1'b0;
    unique case (state_q)
      ST_CAP: begin
        in_ready = 1'b1;
        cap_wr   = in_valid;
      end
      ST_DEC: cap_clr = 1'b1;
      ST_REPLAY: begin
        core_valid = 1'b1;
        core_data  = rep_byte;
        core_last  = done_q && at_end;
      end
      ST_PASS: begin
        if (route_q == RT_STRM) begin
          strm_valid = in_valid;
          strm_data  = in_data;
          strm_last  = in_last;
          in_ready   = strm_ready;
        end else begin
          core_valid = in_valid;
          core_data  = in_data;
          core_last  = in_last;
          in_ready   = core_ready;
        end
      end
      ST_DRAIN: in_ready = 1'b1;
      default: ;
    endcase
  end

  assign core_err = core_valid && err_q;
  assign strm_ctx = strm_valid && ctx_q;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_CAP:
        if (in_fire && (in_last || cap_cnt == LAST_IDX)) state_d = ST_DEC;
      ST_DEC:
        unique case (route)
          RT_CORE: state_d = ST_REPLAY;
          RT_STRM: state_d = done_q ? ST_CAP : ST_PASS;
          default: state_d = done_q ? ST_CAP : ST_DRAIN;
        endcase
      ST_REPLAY:
        if (core_ready && at_end) state_d = done_q ? ST_CAP : ST_PASS;
      ST_PASS, ST_DRAIN:
        if (in_fire && in_last) state_d = ST_CAP;
      default: state_d = ST_CAP;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_CAP;
      route_q <= RT_DROP;
      err_q   <= 1'b0;
      ctx_q   <= 1'b0;
      done_q  <= 1'b0;
      len_q   <= '0;
      rd_idx  <= '0;
    end else begin
      state_q <= state_d;
      if (state_q == ST_CAP && in_fire) done_q <= in_last;
      if (state_q == ST_DEC) begin
        route_q <= route;
        err_q   <= short_err;
        ctx_q   <= ctx_mode;
        len_q   <= cap_cnt;
        rd_idx  <= IDX_ET;
      end
      if (state_q == ST_REPLAY && core_ready && !at_end) rd_idx <= rd_idx + 1'b1;
    end
  end

  // R8
  one_sink_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(core_valid && strm_valid));

  // R8
  route_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_PASS && $past(state_q == ST_PASS)) |-> $stable(route_q));

  // R2
  drop_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_DRAIN) |-> (!core_valid && !strm_valid));

  // R9
  replay_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_REPLAY && !core_ready) |=> (core_valid && $stable(core_data) && !in_ready));
endmodule

// File: rtl/eth_ingress_steer.sv
`timescale 1ns/1ps
module eth_ingress_steer
  import ings_pkg::*;
#(
  parameter logic [15:0] UDP_PORT = 16'd1000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [47:0] local_mac,
  input  logic [31:0] local_ip,
  input  logic        ctx_mode,
  input  logic        in_valid,
  input  logic [7:0]  in_data,
  input  logic        in_last,
  output logic        in_ready,
  output logic        core_valid,
  output logic [7:0]  core_data,
  output logic        core_last,
  output logic        core_err,
  input  logic        core_ready,
  output logic        strm_valid,
  output logic [7:0]  strm_data,
  output logic        strm_last,
  output logic        strm_ctx,
  input  logic        strm_ready
);
  logic [BYTE_W-1:0] hdr [HDR_LEN];
  logic [CNT_W-1:0]  cap_cnt;
  logic              cap_wr, cap_clr, short_err;
  route_e            route;

  ings_hdr_store #(.LEN(HDR_LEN), .CW(CNT_W)) u_store (
    .clk(clk), .rst_n(rst_n), .wr_en(cap_wr), .wr_byte(in_data),
    .clr(cap_clr), .hdr(hdr), .cnt(cap_cnt)
  );

  ings_match #(.LEN(HDR_LEN), .CW(CNT_W), .PORT(UDP_PORT)) u_match (
    .hdr(hdr), .len(cap_cnt), .local_mac(local_mac), .local_ip(local_ip),
    .route(route), .short_err(short_err)
  );

  ings_steer #(.LEN(HDR_LEN), .CW(CNT_W)) u_steer (
    .clk(clk), .rst_n(rst_n), .ctx_mode(ctx_mode),
    .in_valid(in_valid), .in_data(in_data), .in_last(in_last), .in_ready(in_ready),
    .cap_wr(cap_wr), .cap_clr(cap_clr), .cap_cnt(cap_cnt), .hdr(hdr),
    .route(route), .short_err(short_err),
    .core_valid(core_valid), .core_data(core_data), .core_last(core_last),
    .core_err(core_err), .core_ready(core_ready),
    .strm_valid(strm_valid), .strm_data(strm_data), .strm_last(strm_last),
    .strm_ctx(strm_ctx), .strm_ready(strm_ready)
  );
endmodule

// File: tb/eth_ingress_steer_tb_top.sv
`timescale 1ns/1ps
module eth_ingress_steer_tb_top;
  localparam logic [47:0] MAC = 48'h021A_2B3C_4D5E;
  localparam logic [31:0] IP  = 32'hC0A8_0A07;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic       ctx_mode = 1'b0;
  logic       in_valid = 1'b0, in_last = 1'b0, in_ready;
  logic [7:0] in_data = '0;
  logic       core_valid, core_last, core_err, core_ready = 1'b0;
  logic [7:0] core_data, strm_data;
  logic       strm_valid, strm_last, strm_ctx, strm_ready = 1'b0;

  eth_ingress_steer dut_i (
    .clk(clk), .rst_n(rst_n), .local_mac(MAC), .local_ip(IP), .ctx_mode(ctx_mode),
    .in_valid(in_valid), .in_data(in_data), .in_last(in_last), .in_ready(in_ready),
    .core_valid(core_valid), .core_data(core_data), .core_last(core_last),
    .core_err(core_err), .core_ready(core_ready),
    .strm_valid(strm_valid), .strm_data(strm_data), .strm_last(strm_last),
    .strm_ctx(strm_ctx), .strm_ready(strm_ready)
  );

  int n_chk = 0, n_fail = 0;
  logic [7:0] fr[$], exp_q[$], got_c[$], got_s[$];
  int  exp_route;
  bit  exp_err, ctx_now, stall, tx_busy, both_seen;
  int  c_last_cnt, c_last_pos, s_last_cnt, s_last_pos, c_err_bad, s_ctx_bad;

  task automatic chk(bit ok, string req, string what, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    #1;
    core_ready = !stall && ($urandom % 4 != 0);
    strm_ready = !stall && ($urandom % 4 != 0);
  end

  always @(negedge clk) if (rst_n) begin
    if (core_valid && strm_valid) both_seen = 1'b1;
    if (core_valid && core_ready) begin
      got_c.push_back(core_data);
      if (core_last) begin c_last_cnt++; c_last_pos = got_c.size(); end
      if (core_err !== exp_err) c_err_bad++;
    end
    if (strm_valid && strm_ready) begin
      got_s.push_back(strm_data);
      if (strm_last) begin s_last_cnt++; s_last_pos = got_s.size(); end
      if (strm_ctx !== ctx_now) s_ctx_bad++;
    end
  end

  // dst: 0 local, 1 broadcast, 2 foreign; et: 0 IPv4, 1 ARP, 2 other
  task automatic build(int dst, int et, bit vihl_ok, bit proto_ok, bit ip_ok,
                       bit port_ok, int pay, int trunc);
    logic [47:0] d;
    logic [31:0] a;
    logic [15:0] p;
    fr.delete();
    d = (dst == 0) ? MAC : (dst == 1) ? 48'hFFFF_FFFF_FFFF : (MAC ^ 48'h1);
    for (int k = 0; k < 6; k++) fr.push_back(d[47 - 8*k -: 8]);
    for (int k = 0; k < 6; k++) fr.push_back(8'($urandom));
    if (et == 0)      begin fr.push_back(8'h08); fr.push_back(8'h00); end
    else if (et == 1) begin fr.push_back(8'h08); fr.push_back(8'h06); end
    else              begin fr.push_back(8'h86); fr.push_back(8'hDD); end
    for (int k = 14; k < 42; k++) fr.push_back(8'($urandom));
    a = ip_ok ? IP : (IP ^ 32'h100);
    p = port_ok ? 16'd1000 : 16'd1001;
    fr[14] = vihl_ok ? 8'h45 : 8'h46;
    fr[23] = proto_ok ? 8'd17 : 8'd6;
    for (int k = 0; k < 4; k++) fr[30 + k] = a[31 - 8*k -: 8];
    fr[36] = p[15:8];
    fr[37] = p[7:0];
    for (int k = 0; k < pay; k++) fr.push_back(8'($urandom));
    if (trunc > 0) while (fr.size() > trunc) void'(fr.pop_back());
  endtask

  task automatic compute_expect();
    int n = fr.size();
    logic [47:0] d;
    bit ip4, hit;
    exp_q.delete();
    exp_err = 1'b0;
    exp_route = 0;
    if (n >= 6) begin
      for (int k = 0; k < 6; k++) d[47 - 8*k -: 8] = fr[k];
      if (d == MAC || d == 48'hFFFF_FFFF_FFFF) exp_route = 1;
    end
    if (exp_route != 0) begin
      ip4 = (n >= 14) && fr[12] == 8'h08 && fr[13] == 8'h00;
      hit = ip4 && n >= 42 && fr[14] == 8'h45 && fr[23] == 8'd17 &&
            {fr[30], fr[31], fr[32], fr[33]} == IP && {fr[36], fr[37]} == 16'd1000;
      if (hit) begin
        exp_route = 2;
        for (int k = 42; k < n; k++) exp_q.push_back(fr[k]);
      end else begin
        exp_err = (n < 14) || (ip4 && n < 42);
        exp_q.push_back(n > 12 ? fr[12] : 8'h00);
        exp_q.push_back(n > 13 ? fr[13] : 8'h00);
        for (int k = 14; k < n; k++) exp_q.push_back(fr[k]);
      end
    end
  endtask

  task automatic send_frame();
    int i = 0;
    int n = fr.size();
    bit took = 1'b0;
    tx_busy = 1'b1;
    while (i < n) begin
      @(posedge clk); #1;
      if (took) begin in_valid = 1'b0; in_last = 1'b0; took = 1'b0; end
      if (!in_valid && ($urandom % 5 != 0)) begin
        in_valid = 1'b1; in_data = fr[i]; in_last = (i == n - 1);
      end
      @(negedge clk);
      if (in_valid && in_ready) begin i++; took = 1'b1; end
    end
    @(posedge clk); #1;
    in_valid = 1'b0; in_last = 1'b0;
    tx_busy = 1'b0;
  endtask

  task automatic check_frame(string name);
    bit want_c, want_s;
    int bad = -1;
    int sz;
    logic [7:0] q[$];
    repeat (90) @(posedge clk);
    @(negedge clk);
    want_c = (exp_route == 1);
    want_s = (exp_route == 2) && (exp_q.size() > 0);
    chk((got_c.size() > 0) == want_c, "R1 R2", {name, " register sink beats"},
        got_c.size(), want_c ? exp_q.size() : 0);
    chk((got_s.size() > 0) == want_s, "R4", {name, " stream sink beats"},
        got_s.size(), want_s ? exp_q.size() : 0);
    if (want_c || want_s) begin
      if (want_c) q = got_c; else q = got_s;
      sz = q.size();
      for (int k = 0; k < sz && k < exp_q.size(); k++)
        if (q[k] !== exp_q[k] && bad < 0) bad = k;
      chk(sz == exp_q.size() && bad < 0, want_c ? "R3 R9" : "R4 R9",
          {name, " byte count / first bad index"}, bad < 0 ? sz : bad, exp_q.size());
      if (want_c)
        chk(c_last_cnt == 1 && c_last_pos == sz, "R3", {name, " last beat position"},
            c_last_pos, sz);
      else
        chk(s_last_cnt == 1 && s_last_pos == sz, "R4", {name, " last beat position"},
            s_last_pos, sz);
    end
    if (want_c) chk(c_err_bad == 0, exp_err ? "R5" : "R6", {name, " error flag beats wrong"},
                    c_err_bad, 0);
    if (want_s) chk(s_ctx_bad == 0, "R7", {name, " context flag beats wrong"}, s_ctx_bad, 0);
    chk(!both_seen, "R8", {name, " both sinks valid"}, both_seen, 0);
    got_c.delete(); got_s.delete();
    c_last_cnt = 0; c_last_pos = 0; s_last_cnt = 0; s_last_pos = 0;
    c_err_bad = 0; s_ctx_bad = 0; both_seen = 1'b0;
  endtask

  task automatic run_frame(string name);
    ctx_now = 1'($urandom);
    ctx_mode = ctx_now;
    compute_expect();
    send_frame();
    check_frame(name);
  endtask

  initial begin
    #(150000 * 5);
    n_fail++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [7:0] held;
    bit v1;
    void'($urandom(32'h1DEA_5EED));
    stall = 1'b0;
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    // R10
    chk(in_ready && !core_valid && !strm_valid, "R10", "reset state",
        {in_ready, core_valid, strm_valid}, 3'b100);

    build(0, 0, 1, 1, 1, 1, 10, 0);  run_frame("stream hit");
    build(1, 1, 1, 1, 1, 1, 8, 0);   run_frame("broadcast arp");
    build(2, 0, 1, 1, 1, 1, 12, 0);  run_frame("foreign mac dropped");
    build(0, 0, 1, 1, 1, 1, 0, 5);   run_frame("5-byte runt dropped");
    build(0, 1, 1, 1, 1, 1, 0, 13);  run_frame("13-byte short");
    build(0, 1, 1, 1, 1, 1, 0, 12);  run_frame("12-byte short");
    build(0, 0, 1, 1, 1, 1, 0, 30);  run_frame("ipv4 cut at 30");
    build(0, 0, 1, 1, 1, 1, 0, 0);   run_frame("stream hit empty payload");
    build(0, 0, 1, 1, 1, 1, 1, 0);   run_frame("stream hit one byte");
    build(0, 0, 1, 1, 1, 0, 6, 0);   run_frame("port 1001");
    build(0, 0, 1, 0, 1, 1, 6, 0);   run_frame("tcp protocol");
    build(0, 0, 0, 1, 1, 1, 6, 0);   run_frame("ip options");
    build(1, 0, 1, 1, 0, 1, 6, 0);   run_frame("foreign ip");
    build(0, 1, 1, 1, 1, 1, 0, 14);  run_frame("arp exactly 14");

    // R9 directed stall during header replay
    build(0, 1, 1, 1, 1, 1, 20, 0);
    ctx_now = 1'b0; ctx_mode = 1'b0;
    compute_expect();
    stall = 1'b1;
    fork send_frame(); join_none
    repeat (110) @(posedge clk);
    @(negedge clk);
    held = core_data; v1 = core_valid;
    repeat (6) @(negedge clk);
    chk(v1 && core_valid && core_data == held && held == fr[12] && !in_ready, "R9",
        "stalled replay beat", {v1, core_valid, in_ready}, 3'b110);
    stall = 1'b0;
    wait (!tx_busy);
    check_frame("stall release");

    for (int f = 0; f < 60; f++) begin
      int r = $urandom % 4;
      int dsel = (r < 2) ? 0 : r - 1;
      int pay = $urandom % 24;
      int full = 42 + pay;
      int tr = ($urandom % 5 == 0) ? 1 + ($urandom % full) : 0;
      build(dsel, $urandom % 3, $urandom % 4 != 0, $urandom % 4 != 0,
            $urandom % 4 != 0, $urandom % 4 != 0, pay, tr);
      run_frame("random");
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule